// File: doc/BRIEF.md
# Rank Interleave Decoder

The block turns a channel address into a rank selection inside one memory channel. A small table of rules splits the channel address space into consecutive regions. Each rule has an upper limit and four way entries. Each way entry names a rank and gives a signed offset counted in virtual-rank units. The decoder finds the region that holds the address and uses two address bits to pick one of the four ways. It then reports the rank, the DIMM that holds the rank, and the address local to that rank.

Which two address bits pick the way depends on the page policy, given on a lookup input. The rule also has an interleave factor of 1, 2 or 4, which divides the offset-adjusted address. The factor is not programmed directly: the table works it out from repeated rank numbers among the four ways each time a way entry is written. Lookups take one cycle. Configuration writes go through a simple write port.

Top module: `rank_ilv_decoder`

## Requirements
- R1: After reset, `rs_valid` is 0 and every rule limit is 0, so every lookup misses until limits are programmed.
- R2: `rs_valid` is high in exactly the cycle after a cycle in which `lk_valid` was high, and the result belongs to that lookup.
- R3: Rule i hits when the limit of rule i-1 (0 for rule 0) is less than or equal to the address and the address is below the limit of rule i. The lowest-numbered such rule wins. A rule whose limit does not exceed its lower bound never hits.
- R4: The interleave factor of a rule is 1 when all four ways hold the same rank. It is 2 when way 0's rank equals the rank of at least one other way, and 4 otherwise. The factor is recomputed from the stored ranks on every way write.
- R5: With `lk_closed_page`=1, address bits [7:6] select the way, and bits [5:0] of `rs_addr` equal those of the lookup address.
- R6: With `lk_closed_page`=0, address bits [13:12] select the way, and bits [11:0] of `rs_addr` equal those of the lookup address.
- R7: `rs_addr` is computed in three steps. First, form S = address + (sign-extended way offset × 2^VRANK_LG), taken modulo 2^ADDR_W. Second, shift S right logically by log2 of the factor. Third, replace the low granule bits (6 or 12, see R5/R6) with the lookup address bits.
- R8: On a hit, `rs_rank` is the rank of the selected way and `rs_dimm` is that rank shifted right by 2.
- R9: On a miss, `rs_hit` is 0 and `rs_rank`, `rs_dimm` and `rs_addr` are all ones.
- R10: A configuration write sampled at a clock edge affects lookups sampled at later edges. A lookup sampled at the same edge as the write uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_limit_we | input | 1 | Write `cfg_limit` into rule `cfg_rule` |
| cfg_way_we | input | 1 | Write `cfg_rank`/`cfg_offset` into way `cfg_way` of rule `cfg_rule` |
| cfg_rule | input | RULE_W | Rule index for writes |
| cfg_way | input | 2 | Way index for way writes |
| cfg_limit | input | ADDR_W | Exclusive upper limit of the rule |
| cfg_rank | input | RANK_W | Rank number of the way |
| cfg_offset | input | OFF_W | Signed offset of the way in virtual-rank units |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Channel address to decode |
| lk_closed_page | input | 1 | 1 = closed-page way select, 0 = open-page |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | A rule matched |
| rs_rank | output | RANK_W | Selected rank, all ones on miss |
| rs_dimm | output | RANK_W-2 | DIMM number, all ones on miss |
| rs_addr | output | ADDR_W | Rank-local address, all ones on miss |

## Verification
A wrongly stored interleave factor shows up in `rs_addr` on the next lookup into that rule. The effect is a value off by a factor of two or four above the granule bits, while rank and DIMM stay correct. A wrong limit or a broken priority chain shows up as a wrong rank or a false hit or miss for addresses at rule boundaries. That is why the sweep probes the first and last address of every region. All such faults become visible one cycle after the lookup that exercises them.

// File: rtl/rid_pkg.sv
package rid_pkg;

  // interleave codes double as right-shift amounts
  localparam logic [1:0] ILV_X1 = 2'd0;
  localparam logic [1:0] ILV_X2 = 2'd1;
  localparam logic [1:0] ILV_X4 = 2'd2;

  typedef logic [7:0] rank_word_t;

  // factor from the four way ranks (R4)
  function automatic logic [1:0] ilv_from_ranks(input rank_word_t r0, input rank_word_t r1,
                                                input rank_word_t r2, input rank_word_t r3);
    if (r0 == r1 && r0 == r2 && r0 == r3) return ILV_X1;
    if (r0 == r1 || r0 == r2 || r0 == r3) return ILV_X2;
    return ILV_X4;
  endfunction

  // way index from page policy (R5, R6)
  function automatic logic [1:0] way_pick(input logic closed, input logic [1:0] b7_6,
                                          input logic [1:0] b13_12);
    return closed ? b7_6 : b13_12;
  endfunction

endpackage

// File: rtl/rid_rule_table.sv
module rid_rule_table
  import rid_pkg::*;
#(
  parameter int NUM_RULES = 4,
  parameter int ADDR_W    = 34,
  parameter int RANK_W    = 4,
  parameter int OFF_W     = 8,
  localparam int RULE_W   = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          limit_we,
  input  logic                                          way_we,
  input  logic [RULE_W-1:0]                             wr_rule,
  input  logic [1:0]                                    wr_way,
  input  logic [ADDR_W-1:0]                             wr_limit,
  input  logic [RANK_W-1:0]                             wr_rank,
  input  logic [OFF_W-1:0]                              wr_offset,
  output logic [NUM_RULES-1:0][ADDR_W-1:0]              limit_o,
  output logic [NUM_RULES-1:0][3:0][RANK_W-1:0]         rank_o,
  output logic [NUM_RULES-1:0][3:0][OFF_W-1:0]          offset_o,
  output logic [NUM_RULES-1:0][1:0]                     ilv_o
);

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    logic [ADDR_W-1:0]          lim_q;
    logic [3:0][RANK_W-1:0]     rk_q;
    logic [3:0][OFF_W-1:0]      of_q;
    logic [1:0]                 ilv_q;
    logic [3:0][RANK_W-1:0]     rk_next;
    logic                       hit_lim;
    logic                       hit_way;

    assign hit_lim = limit_we && (wr_rule == RULE_W'(g));
    assign hit_way = way_we   && (wr_rule == RULE_W'(g));

    always_comb begin
      rk_next = rk_q;
      rk_next[wr_way] = wr_rank;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lim_q <= '0;
        rk_q  <= '0;
        of_q  <= '0;
        ilv_q <= ILV_X1;
      end else begin
        if (hit_lim) lim_q <= wr_limit;
        if (hit_way) begin
          rk_q[wr_way] <= wr_rank;
          of_q[wr_way] <= wr_offset;
          ilv_q <= ilv_from_ranks(rank_word_t'(rk_next[0]), rank_word_t'(rk_next[1]),
                                  rank_word_t'(rk_next[2]), rank_word_t'(rk_next[3]));
        end
      end
    end

    assign limit_o[g]  = lim_q;
    assign rank_o[g]   = rk_q;
    assign offset_o[g] = of_q;
    assign ilv_o[g]    = ilv_q;

    // R4: identical ranks in all ways must leave a factor of one stored
    a_r4_same_rank_x1 : assert property (@(posedge clk) disable iff (!rst_n)
      (rk_q[0] == rk_q[1] && rk_q[0] == rk_q[2] && rk_q[0] == rk_q[3]) |-> ilv_q == ILV_X1);
    // R4: way 0 unique among the ways must leave a factor of four
    a_r4_unique_x4 : assert property (@(posedge clk) disable iff (!rst_n)
      (rk_q[0] != rk_q[1] && rk_q[0] != rk_q[2] && rk_q[0] != rk_q[3]) |-> ilv_q == ILV_X4);
  end

endmodule

// File: rtl/rid_match.sv
module rid_match #(
  parameter int NUM_RULES = 4,
  parameter int ADDR_W    = 34,
  localparam int RULE_W   = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic [NUM_RULES-1:0][ADDR_W-1:0] limit_i,
  input  logic [ADDR_W-1:0]                addr_i,
  output logic [NUM_RULES-1:0]             in_range_o,
  output logic [NUM_RULES-1:0]             grant_o,
  output logic [RULE_W-1:0]                sel_o,
  output logic                             hit_o
);

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_cmp
    logic [ADDR_W-1:0] lower;
    if (g == 0) begin : g_first
      assign lower = '0;
    end else begin : g_rest
      assign lower = limit_i[g-1];
    end
    assign in_range_o[g] = (addr_i >= lower) && (addr_i < limit_i[g]);
  end

  // lowest index wins
  always_comb begin
    grant_o = '0;
    sel_o   = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (in_range_o[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        sel_o = RULE_W'(i);
      end
    end
  end

  assign hit_o = |in_range_o;

endmodule

// File: rtl/rid_xlate.sv
module rid_xlate
  import rid_pkg::*;
#(
  parameter int ADDR_W   = 34,
  parameter int RANK_W   = 4,
  parameter int OFF_W    = 8,
  parameter int VRANK_LG = 24
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       closed_i,
  input  logic [3:0][RANK_W-1:0]     rank_i,
  input  logic [3:0][OFF_W-1:0]      offset_i,
  input  logic [1:0]                 ilv_i,
  output logic [1:0]                 way_o,
  output logic [RANK_W-1:0]          rank_o,
  output logic [ADDR_W-1:0]          raddr_o
);

  localparam int EXT_W = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] MASK_CLOSED = ADDR_W'(64'h3f);
  localparam logic [ADDR_W-1:0] MASK_OPEN   = ADDR_W'(64'hfff);

  logic [OFF_W-1:0]  off_sel;
  logic [ADDR_W-1:0] off_bytes;
  logic [ADDR_W-1:0] shifted_sum;
  logic [ADDR_W-1:0] quotient;
  logic [ADDR_W-1:0] gran_mask;

  assign way_o       = way_pick(closed_i, addr_i[7:6], addr_i[13:12]);
  assign rank_o      = rank_i[way_o];
  assign off_sel     = offset_i[way_o];
  assign off_bytes   = {{EXT_W{off_sel[OFF_W-1]}}, off_sel} << VRANK_LG;
  assign shifted_sum = addr_i + off_bytes;
  assign quotient    = shifted_sum >> ilv_i;
  assign gran_mask   = closed_i ? MASK_CLOSED : MASK_OPEN;
  assign raddr_o     = (quotient & ~gran_mask) | (addr_i & gran_mask);

endmodule

// File: rtl/rank_ilv_decoder.sv
module rank_ilv_decoder
  import rid_pkg::*;
#(
  parameter int NUM_RULES = 4,
  parameter int ADDR_W    = 34,
  parameter int RANK_W    = 4,
  parameter int OFF_W     = 8,
  parameter int VRANK_LG  = 24,
  localparam int RULE_W   = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1,
  localparam int DIMM_W   = RANK_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_limit_we,
  input  logic               cfg_way_we,
  input  logic [RULE_W-1:0]  cfg_rule,
  input  logic [1:0]         cfg_way,
  input  logic [ADDR_W-1:0]  cfg_limit,
  input  logic [RANK_W-1:0]  cfg_rank,
  input  logic [OFF_W-1:0]   cfg_offset,
  input  logic               lk_valid,
  input  logic [ADDR_W-1:0]  lk_addr,
  input  logic               lk_closed_page,
  output logic               rs_valid,
  output logic               rs_hit,
  output logic [RANK_W-1:0]  rs_rank,
  output logic [DIMM_W-1:0]  rs_dimm,
  output logic [ADDR_W-1:0]  rs_addr
);

  logic [NUM_RULES-1:0][ADDR_W-1:0]      tbl_limit;
  logic [NUM_RULES-1:0][3:0][RANK_W-1:0] tbl_rank;
  logic [NUM_RULES-1:0][3:0][OFF_W-1:0]  tbl_off;
  logic [NUM_RULES-1:0][1:0]             tbl_ilv;

  logic [NUM_RULES-1:0] in_range;
  logic [NUM_RULES-1:0] grant;
  logic [RULE_W-1:0]    sel;
  logic                 any_hit;

  logic [1:0]           way;
  logic [RANK_W-1:0]    xl_rank;
  logic [ADDR_W-1:0]    xl_raddr;

  rid_rule_table #(
    .NUM_RULES(NUM_RULES), .ADDR_W(ADDR_W), .RANK_W(RANK_W), .OFF_W(OFF_W)
  ) table_i (
    .clk(clk), .rst_n(rst_n),
    .limit_we(cfg_limit_we), .way_we(cfg_way_we),
    .wr_rule(cfg_rule), .wr_way(cfg_way), .wr_limit(cfg_limit),
    .wr_rank(cfg_rank), .wr_offset(cfg_offset),
    .limit_o(tbl_limit), .rank_o(tbl_rank), .offset_o(tbl_off), .ilv_o(tbl_ilv)
  );

  rid_match #(.NUM_RULES(NUM_RULES), .ADDR_W(ADDR_W)) match_i (
    .limit_i(tbl_limit), .addr_i(lk_addr),
    .in_range_o(in_range), .grant_o(grant), .sel_o(sel), .hit_o(any_hit)
  );

  rid_xlate #(
    .ADDR_W(ADDR_W), .RANK_W(RANK_W), .OFF_W(OFF_W), .VRANK_LG(VRANK_LG)
  ) xlate_i (
    .addr_i(lk_addr), .closed_i(lk_closed_page),
    .rank_i(tbl_rank[sel]), .offset_i(tbl_off[sel]), .ilv_i(tbl_ilv[sel]),
    .way_o(way), .rank_o(xl_rank), .raddr_o(xl_raddr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_rank  <= '1;
      rs_dimm  <= '1;
      rs_addr  <= '1;
    end else begin
      rs_valid <= lk_valid;
      if (lk_valid) begin
        rs_hit <= any_hit;
        if (any_hit) begin
          rs_rank <= xl_rank;
          rs_dimm <= xl_rank[RANK_W-1:2];
          rs_addr <= xl_raddr;
        end else begin
          rs_rank <= '1;
          rs_dimm <= '1;
          rs_addr <= '1;
        end
      end
    end
  end

  // R3: at most one rule granted, and only one that is in range
  a_r3_grant_onehot : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~in_range) == '0));
  // R2: result valid follows a request by one cycle
  a_r2_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);
  a_r2_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);
  // R5: closed-page granule kept
  a_r5_closed_low_bits : assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_closed_page && any_hit) |=> rs_addr[5:0] == $past(lk_addr[5:0]));
  // R6: open-page granule kept
  a_r6_open_low_bits : assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_closed_page && any_hit) |=> rs_addr[11:0] == $past(lk_addr[11:0]));
  // R9: miss drives all-ones results
  a_r9_miss_ones : assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> (&rs_rank) && (&rs_dimm) && (&rs_addr));
  // R8: DIMM is the upper rank bits on a hit
  a_r8_dimm_of_rank : assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_hit) |-> rs_dimm == rs_rank[RANK_W-1:2]);

endmodule

// File: tb/rank_ilv_decoder_tb.sv
module rank_ilv_decoder_tb_top;

  localparam int AW = 34;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_limit_we = 1'b0, cfg_way_we = 1'b0;
  logic [1:0]    cfg_rule = '0, cfg_way = '0;
  logic [AW-1:0] cfg_limit = '0;
  logic [3:0]    cfg_rank = '0;
  logic [7:0]    cfg_offset = '0;
  logic          lk_valid = 1'b0, lk_closed_page = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          rs_valid, rs_hit;
  logic [3:0]    rs_rank;
  logic [1:0]    rs_dimm;
  logic [AW-1:0] rs_addr;

  int n_tests = 0;
  int n_fail  = 0;

  // bench-side record of programmed configuration
  logic [AW-1:0] m_lim [4];
  logic [3:0]    m_rank[4][4];
  logic [7:0]    m_off [4][4];

  always #2 clk = ~clk;

  rank_ilv_decoder dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_limit_we(cfg_limit_we), .cfg_way_we(cfg_way_we),
    .cfg_rule(cfg_rule), .cfg_way(cfg_way), .cfg_limit(cfg_limit),
    .cfg_rank(cfg_rank), .cfg_offset(cfg_offset),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_closed_page(lk_closed_page),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_rank(rs_rank),
    .rs_dimm(rs_dimm), .rs_addr(rs_addr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_limit(input int r, input logic [AW-1:0] v);
    @(negedge clk);
    cfg_limit_we = 1'b1; cfg_rule = 2'(r); cfg_limit = v;
    m_lim[r] = v;
    @(negedge clk);
    cfg_limit_we = 1'b0;
  endtask

  task automatic write_way(input int r, input int w, input logic [3:0] rk, input logic [7:0] of);
    @(negedge clk);
    cfg_way_we = 1'b1; cfg_rule = 2'(r); cfg_way = 2'(w); cfg_rank = rk; cfg_offset = of;
    m_rank[r][w] = rk; m_off[r][w] = of;
    @(negedge clk);
    cfg_way_we = 1'b0;
  endtask

  // expected result straight from the requirements
  task automatic model(input logic [AW-1:0] a, input logic closed,
                       output logic hit, output logic [3:0] rk,
                       output logic [1:0] dm, output logic [AW-1:0] ra);
    logic [AW-1:0] lo;
    int same;
    int sh;
    int w;
    logic [63:0] s;
    logic [63:0] gm;
    hit = 1'b0; rk = '1; dm = '1; ra = '1;
    lo = '0;
    for (int r = 0; r < 4; r++) begin
      if (!hit && a >= lo && a < m_lim[r]) begin
        hit = 1'b1;
        w = closed ? int'(a[7:6]) : int'(a[13:12]);
        same = 0;
        for (int k = 1; k < 4; k++) if (m_rank[r][k] == m_rank[r][0]) same++;
        sh = (same == 3) ? 0 : (same >= 1) ? 1 : 2;
        s = ({30'd0, a} + ({{56{m_off[r][w][7]}}, m_off[r][w]} << 24)) & 64'h3_FFFF_FFFF;
        s = s >> sh;
        gm = closed ? 64'h3f : 64'hfff;
        ra = AW'((s & ~gm) | ({30'd0, a} & gm));
        rk = m_rank[r][w];
        dm = rk[3:2];
      end
      lo = m_lim[r];
    end
  endtask

  task automatic lookup(input logic [AW-1:0] a, input logic closed, input string tag);
    logic eh; logic [3:0] er; logic [1:0] ed; logic [AW-1:0] ea;
    model(a, closed, eh, er, ed, ea);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_closed_page = closed;
    @(negedge clk);
    lk_valid = 1'b0;
    check({tag, " R2 valid"}, 64'(rs_valid), 64'd1);
    check({tag, " R3/R9 hit"}, 64'(rs_hit), 64'(eh));
    check({tag, " R8 rank"}, 64'(rs_rank), 64'(er));
    check({tag, " R8 dimm"}, 64'(rs_dimm), 64'(ed));
    check({tag, " R7 raddr"}, 64'(rs_addr), 64'(ea));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    logic [63:0] x;
    for (int r = 0; r < 4; r++) begin
      m_lim[r] = '0;
      for (int w = 0; w < 4; w++) begin m_rank[r][w] = '0; m_off[r][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 valid idle", 64'(rs_valid), 64'd0);
    lookup(34'h0_0000_1000, 1'b1, "R1 miss after reset");
    @(negedge clk);
    check("R2 valid drops", 64'(rs_valid), 64'd0);

    // rule 0: one rank everywhere (factor 1)
    write_limit(0, 34'h0_4000_0000);
    write_way(0, 0, 4'd3, 8'd0);  write_way(0, 1, 4'd3, 8'd1);
    write_way(0, 2, 4'd3, 8'd2);  write_way(0, 3, 4'd3, 8'hFF);
    // rule 1: ranks 5,9,5,9 (factor 2)
    write_limit(1, 34'h1_0000_0000);
    write_way(1, 0, 4'd5, 8'hC0); write_way(1, 1, 4'd9, 8'hC0);
    write_way(1, 2, 4'd5, 8'hBF); write_way(1, 3, 4'd9, 8'hBE);
    // rule 2: ranks 0,1,2,7 (factor 4)
    write_limit(2, 34'h2_0000_0000);
    write_way(2, 0, 4'd0, 8'hFD); write_way(2, 1, 4'd1, 8'h04);
    write_way(2, 2, 4'd2, 8'h80); write_way(2, 3, 4'd7, 8'h7F);
    // rule 3: empty range (limit equals lower bound)
    write_limit(3, 34'h2_0000_0000);
    write_way(3, 0, 4'd12, 8'd0); write_way(3, 1, 4'd13, 8'd0);
    write_way(3, 2, 4'd14, 8'd0); write_way(3, 3, 4'd15, 8'd0);

    // R3: boundaries of every region
    lookup(34'h0_0000_0000, 1'b1, "R3 first addr");
    lookup(34'h0_3FFF_FFFF, 1'b0, "R3 top of rule0");
    lookup(34'h0_4000_0000, 1'b1, "R3 base of rule1");
    lookup(34'h0_FFFF_FFFF, 1'b0, "R3 top of rule1");
    lookup(34'h1_0000_0000, 1'b1, "R3 base of rule2");
    lookup(34'h1_FFFF_FFFF, 1'b0, "R3 top of rule2");
    lookup(34'h2_0000_0000, 1'b1, "R3/R9 empty rule3 miss");
    lookup(34'h3_FFFF_FFFF, 1'b0, "R9 top miss");

    // R5 / R6: each way under both page policies, R4 factors per rule
    for (int r = 0; r < 3; r++) begin
      for (int w = 0; w < 4; w++) begin
        lookup((r == 0 ? 34'h0_1234_5000 : r == 1 ? 34'h0_8765_4000 : 34'h1_5555_0000)
               | (AW'(w) << 6) | 34'h2A, 1'b1, "R5/R4 closed way");
        lookup((r == 0 ? 34'h0_1230_0000 : r == 1 ? 34'h0_8760_0000 : 34'h1_5550_0000)
               | (AW'(w) << 12) | 34'hABC | (AW'(3 - w) << 6), 1'b0, "R6/R4 open way");
      end
    end

    // sweep of pseudo-random addresses and page policies
    x = 64'h1234_5678_9ABC_DEF0;
    for (int i = 0; i < 1500; i++) begin
      x = x * 64'd6364136223846793005 + 64'd1442695040888963407;
      lookup(x[33:0], x[40], "R7 sweep");
    end

    // R4: rewrite one way of rule 2 so way 0's rank repeats -> factor 2
    write_way(2, 3, 4'd0, 8'h7F);
    lookup(34'h1_2345_6FC0, 1'b1, "R4 recompute to x2");
    lookup(34'h1_2345_6000 | 34'h3ABC, 1'b0, "R4 recompute open");
    write_way(2, 1, 4'd0, 8'h04); write_way(2, 2, 4'd0, 8'h80);
    lookup(34'h1_2345_60C0, 1'b1, "R4 recompute to x1");

    // R10: limit write and lookup sampled at the same edge
    @(negedge clk);
    cfg_limit_we = 1'b1; cfg_rule = 2'd3; cfg_limit = 34'h3_0000_0000;
    lk_valid = 1'b1; lk_addr = 34'h2_8000_0040; lk_closed_page = 1'b1;
    @(negedge clk);
    cfg_limit_we = 1'b0; lk_valid = 1'b0;
    check("R10 same-edge lookup misses", 64'(rs_hit), 64'd0);
    check("R10 same-edge rank ones", 64'(rs_rank), 64'hF);
    m_lim[3] = 34'h3_0000_0000;
    lookup(34'h2_8000_0040, 1'b1, "R10 later lookup hits");
    lookup(34'h2_8000_30C0, 1'b0, "R10/R8 rule3 open");

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule